// File: doc/BRIEF.md
# Per-Channel Overload Latch-Off with Blanking Window

This block guards the eight-bit control latch of a low-side output driver array against overloaded channels. Each time a new control byte is committed (a one-cycle pulse derived from the rising edge of the select line), the byte is written into the latch and a blanking timer starts. While the timer runs, overload indications are ignored, so loads with a large inrush current can turn on without being shut off.

Each channel has a comparator flag that is high when the output node sits above the fault threshold. The flags arrive asynchronously and pass through a two-stage synchroniser. Once the blanking window has expired, the block checks every channel on every system clock. Any channel that is switched on while its synchronised flag is high has its own latch bit cleared. The other channels keep their state. A cleared bit stays off until the next control byte is committed. The active-low reset empties the latch at any moment, whatever state the fault logic is in.

The block has three states:
- IDLE: after reset, no byte has been committed yet.
- BLANK: the timer is running.
- ARMED: fault checking is enabled.

It has three transitions:
- *load*: any state goes to BLANK on a commit pulse.
- *expire*: BLANK goes to ARMED when the timer reaches zero.
- *reset*: any state goes to IDLE on reset.

Top module: `fault_latchoff`

## Requirements
- R1: While reset is low, and after it is released, `drv_q` is all zeros and `blank_on` is 0, until the first commit pulse.
- R2: A commit pulse (`commit` high at a clock edge) loads `ctrl_in` into `drv_q` at that edge and raises `blank_on` at that edge. A `drv_q` bit of 1 means the channel is on; 0 means off.
- R3: After the edge that loads a byte, `blank_on` stays high for exactly BLANK_CYCLES clock cycles, then falls.
- R4: While `blank_on` is high, no `sense_hi` value changes any `drv_q` bit.
- R5: In ARMED, a channel whose `drv_q` bit is 1 and whose synchronised `sense_hi` bit is 1 is cleared at the next edge. The first edge that can clear a bit is BLANK_CYCLES+1 edges after the loading edge.
- R6: A fault clear changes only the faulty channel's bit; every other bit of `drv_q` keeps its value.
- R7: A cleared bit stays 0 after its `sense_hi` bit returns low, until the next commit pulse. No `drv_q` bit ever rises except on a commit pulse.
- R8: A commit pulse while `blank_on` is high reloads the byte and restarts the full BLANK_CYCLES window from that edge.
- R9: Asserting reset low at any time, including during blanking and in ARMED, clears `drv_q` and `blank_on` immediately.
- R10: A high `sense_hi` bit on a channel whose `drv_q` bit is 0 has no effect. A `sense_hi` bit that rises during ARMED clears its channel on the third clock edge after it rises (two synchroniser stages plus the latch).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| commit | input | 1 | One-cycle pulse: commit a new control byte |
| ctrl_in | input | CH | Control byte from the shift register, 1 = channel on |
| sense_hi | input | CH | Asynchronous per-channel flags, 1 = output above fault threshold |
| drv_q | output | CH | Corrected control latch driving the output stages |
| blank_on | output | 1 | High while the blanking timer runs |

## Verification
The hardest cases to reach from the ports are the edges of the blanking window: the cycle where `blank_on` has just fallen but no clear has happened yet, and the cycle after it where the first clear lands. The bench sets the fault flags well before the commit pulse so the synchroniser is already full. It then counts edges from the loading edge and checks `drv_q` at BLANK_CYCLES and at BLANK_CYCLES+1. A restart in the middle of the window and a flag that rises only after arming exercise the two remaining timing paths: the timer reload and the synchroniser latency.

// File: rtl/fault_latchoff_pkg.sv
package fault_latchoff_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ARMED = 2'd2
    } guard_state_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[i] <= '0;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/blank_fsm.sv
module blank_fsm
    import fault_latchoff_pkg::*;
#(
    parameter int BLANK_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic blank_on,
    output logic armed
);
    localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BLANK_CYCLES - 1);

    guard_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    state_nx = ST_BLANK;
                    cnt_nx   = RELOAD;
                end
            end
            ST_BLANK: begin
                if (load) begin
                    cnt_nx = RELOAD;
                end else if (cnt == '0) begin
                    state_nx = ST_ARMED;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_ARMED: begin
                if (load) begin
                    state_nx = ST_BLANK;
                    cnt_nx   = RELOAD;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        blank_on = 1'b0;
        armed    = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_BLANK: blank_on = 1'b1;
            ST_ARMED: armed    = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/fault_latchoff.sv
module fault_latchoff #(
    parameter int CH           = 8,
    parameter int BLANK_CYCLES = 20000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [CH-1:0] ctrl_in,
    input  logic [CH-1:0] sense_hi,
    output logic [CH-1:0] drv_q,
    output logic          blank_on
);
    logic [CH-1:0] sense_s;
    logic          armed;

    flag_sync #(.W(CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sense_hi),
        .q     (sense_s)
    );

    blank_fsm #(.BLANK_CYCLES(BLANK_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .blank_on (blank_on),
        .armed    (armed)
    );

    // control latch: commit wins over fault clearing in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      drv_q <= '0;
        else if (commit) drv_q <= ctrl_in;
        else if (armed)  drv_q <= drv_q & ~sense_s;
    end
endmodule

// File: rtl/fault_latchoff_chk.sv
module fault_latchoff_chk #(
    parameter int CH           = 8,
    parameter int BLANK_CYCLES = 20000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          commit,
    input logic [CH-1:0] ctrl_in,
    input logic [CH-1:0] sense_s,
    input logic          armed,
    input logic [CH-1:0] drv_q,
    input logic          blank_on
);
    localparam int RUN_W = $clog2(BLANK_CYCLES + 2);
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run <= '0;
        else if (commit)   run <= RUN_W'(1);
        else if (blank_on) run <= run + 1'b1;
        else               run <= '0;
    end

    // R1: latch empty and blanking off while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (drv_q == '0 && !blank_on);
        end
    end

    a_r2_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (drv_q == $past(ctrl_in)) && blank_on);

    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        blank_on |-> (run <= RUN_W'(BLANK_CYCLES)));

    a_r4_hold_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_on && !commit) |=> drv_q == $past(drv_q));

    a_r5_clear_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !commit) |=> drv_q == ($past(drv_q) & ~$past(sense_s)));

    a_r7_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (drv_q & ~$past(drv_q)) == '0);

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && blank_on));
endmodule

bind fault_latchoff fault_latchoff_chk #(.CH(CH), .BLANK_CYCLES(BLANK_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .ctrl_in  (ctrl_in),
    .sense_s  (sense_s),
    .armed    (armed),
    .drv_q    (drv_q),
    .blank_on (blank_on)
);

// File: tb/fault_latchoff_tb.sv
module fault_latchoff_tb;
    localparam int CH = 8;
    localparam int BC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          commit = 1'b0;
    logic [CH-1:0] ctrl_in = '0;
    logic [CH-1:0] sense_hi = '0;
    logic [CH-1:0] drv_q;
    logic          blank_on;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_latchoff #(.CH(CH), .BLANK_CYCLES(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .commit(commit), .ctrl_in(ctrl_in),
        .sense_hi(sense_hi), .drv_q(drv_q), .blank_on(blank_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive a commit pulse; returns at the negedge after the loading edge
    task automatic load(input logic [CH-1:0] b);
        ctrl_in = b;
        commit  = 1'b1;
        step(1);
        commit  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        chk("R1 drv_q in reset", 32'(drv_q), 32'h0);
        chk("R1 blank_on in reset", 32'(blank_on), 32'h0);
        rst_n = 1'b1;
        step(3);
        chk("R1 drv_q after release", 32'(drv_q), 32'h0);
        chk("R1 blank_on after release", 32'(blank_on), 32'h0);
    endtask

    task automatic t_load_window();
        bit held = 1'b1;
        sense_hi = '0;
        load(8'hA5);
        chk("R2 byte loaded", 32'(drv_q), 32'hA5);
        chk("R2 blank_on raised", 32'(blank_on), 32'h1);
        for (int i = 1; i < BC; i++) begin
            step(1);
            if (!blank_on) held = 1'b0;
        end
        chk("R3 blank high for full window", 32'(held), 32'h1);
        step(1);
        chk("R3 blank falls after window", 32'(blank_on), 32'h0);
        step(2);
        chk("R2 byte kept without faults", 32'(drv_q), 32'hA5);
    endtask

    task automatic t_blank_then_clear();
        bit kept = 1'b1;
        sense_hi = 8'h09;
        step(3);
        load(8'h3B);
        for (int i = 1; i < BC; i++) begin
            step(1);
            if (drv_q !== 8'h3B) kept = 1'b0;
        end
        chk("R4 no clear during blanking", 32'(kept), 32'h1);
        step(1);
        chk("R5 no clear at expiry edge", 32'(drv_q), 32'h3B);
        step(1);
        chk("R5 R6 only faulty on bits cleared", 32'(drv_q), 32'h32);
        sense_hi = '0;
        step(4);
        chk("R7 cleared bits stay off", 32'(drv_q), 32'h32);
        load(8'h3B);
        chk("R7 new byte restores bits", 32'(drv_q), 32'h3B);
        step(BC + 3);
    endtask

    task automatic t_restart();
        bit held = 1'b1;
        sense_hi = 8'hFF;
        step(3);
        load(8'h0F);
        step(BC / 2);
        load(8'hF0);
        for (int i = 1; i < BC; i++) begin
            step(1);
            if (!blank_on || drv_q !== 8'hF0) held = 1'b0;
        end
        chk("R8 window restarted by second commit", 32'(held), 32'h1);
        step(1);
        chk("R8 window ends after restart length", 32'(blank_on), 32'h0);
        step(1);
        chk("R8 clears after restarted window", 32'(drv_q), 32'h00);
        sense_hi = '0;
    endtask

    task automatic t_off_and_late();
        sense_hi = 8'h81;
        step(3);
        load(8'h7E);
        step(BC + 4);
        chk("R10 sense on off channels ignored", 32'(drv_q), 32'h7E);
        sense_hi = 8'h85;
        step(2);
        chk("R10 not cleared before sync latency", 32'(drv_q), 32'h7E);
        step(1);
        chk("R10 R6 late fault clears third edge", 32'(drv_q), 32'h7A);
        sense_hi = '0;
    endtask

    task automatic t_async_reset();
        load(8'hCC);
        step(3);
        #1 rst_n = 1'b0;
        #1;
        chk("R9 reset during blanking clears latch", 32'(drv_q), 32'h0);
        chk("R9 reset during blanking drops blank", 32'(blank_on), 32'h0);
        step(1);
        rst_n = 1'b1;
        step(1);
        load(8'h55);
        step(BC + 3);
        #1 rst_n = 1'b0;
        #1;
        chk("R9 reset in armed clears latch", 32'(drv_q), 32'h0);
        step(1);
        rst_n = 1'b1;
        step(2);
        chk("R1 idle after reset, no new byte", 32'(drv_q), 32'h0);
    endtask

    initial begin
        step(1);
        do_reset();
        t_load_window();
        t_blank_then_clear();
        t_restart();
        t_off_and_late();
        t_async_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule